// File: doc/BRIEF.md
# Loop-Invariant Micro-Op Detector

This block examines a loop body that an upstream loop-capture stage has stored, one micro-op per slot. It marks every micro-op whose result cannot change from one iteration to the next, so that replay logic can drop those micro-ops from all later iterations. A micro-op counts as invariant when each register it reads is written by no micro-op of the body. Invariance then spreads forward: a reader of registers whose only in-body writers are already invariant becomes invariant too. The block repeats this marking pass until no new micro-op qualifies, or until it has run as many passes as the body has entries.

Once the analysis settles, the block enters loop mode. While loop mode lasts it presents the mask of removable slots. It also presents a per-register pin request, which tells rename logic to keep the physical register behind each removed result allocated. Removable loads are entered into a small fully associative table of load addresses. Every store issued during loop mode is compared against that table. A match is a memory conflict: the block requests a pipeline flush, leaves loop mode and drops all markings. A loop exit or trap signalled from outside also ends loop mode. Either way the block raises a one-cycle request to restore the register mapping.

Top module: `loop_invariant_detector`

## Requirements
- R1: A body entry of kind ALU (kind code 0) or LOAD (kind code 1), with a destination enabled, is marked removable when every enabled source register is written by no entry inside the body.
- R2: An entry whose enabled sources are written in the body only by entries that are already marked becomes marked as well, through chains as long as the body.
- R3: An entry that reads a register written by an unmarked body entry stays unmarked. This includes a register with several writers of which one is unmarked, and an entry that reads its own destination.
- R4: An entry of kind STORE (kind code 2) is never marked.
- R5: While loop mode is active, pin_mask has bit r set exactly when some marked entry has destination register r. Outside loop mode pin_mask is zero.
- R6: Marked loads occupy the load-address table in ascending slot order. Once its RLT_DEPTH slots are full, later loads stay unmarked, and no entry is evicted for them.
- R7: A store during loop mode whose address equals a tracked load's address gives flush_req and restore_req high for exactly the following cycle. In that same cycle loop_mode, red_mask and pin_mask are zero, and a later analysis of the same body starts with an empty table.
- R8: A store during loop mode whose address matches no tracked load leaves loop_mode, red_mask and flush_req unchanged. This holds even when the address matches a load that was left unmarked.
- R9: loop_end during loop mode gives restore_req high, with flush_req low, for the following cycle, and ends loop mode.
- R10: After reset, and while an analysis is running, loop_mode, red_mask and pin_mask are zero.
- R11: Slots at or beyond body_len are neither marked nor treated as writers of any register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write one body slot (accepted only when no analysis or loop is active) |
| wr_idx | input | IDX_W | Slot index to write |
| wr_kind | input | 2 | 0 ALU, 1 LOAD, 2 STORE |
| wr_src0_en | input | 1 | First source used |
| wr_src0 | input | REG_W | First source register |
| wr_src1_en | input | 1 | Second source used |
| wr_src1 | input | REG_W | Second source register |
| wr_dst_en | input | 1 | Destination used |
| wr_dst | input | REG_W | Destination register |
| wr_addr | input | ADDR_W | Load address of the slot |
| body_len | input | LEN_W | Number of valid slots, sampled throughout the analysis |
| start | input | 1 | Begin analysis (idle only) |
| loop_end | input | 1 | Loop exit or trap |
| st_valid | input | 1 | A store is executing |
| st_addr | input | ADDR_W | Address of that store |
| loop_mode | output | 1 | Analysis settled, markings valid |
| red_mask | output | N_ENT | Removable slots |
| pin_mask | output | NUM_REGS | Registers whose physical copy must stay allocated |
| flush_req | output | 1 | Store conflict flush request |
| restore_req | output | 1 | Register mapping recovery request |

## Verification
The assertions assume that body_len and the body slots stay unchanged from start until loop mode ends. They also assume that start arrives only while the block is idle, and that loop_end is not raised in the same cycle as a conflicting store. The bench writes every body while idle, holds body_len steady across each run, and drives each store or exit on its own in a separate cycle. Mismatched stores are aimed at an address that is in the body but belongs to a load left out because the table was full.

// File: rtl/lid_pkg.sv
package lid_pkg;

    parameter int REG_W   = 4;
    parameter int ADDR_W  = 16;
    localparam int NUM_REGS = 1 << REG_W;

    typedef enum logic [1:0] {
        K_ALU   = 2'd0,
        K_LOAD  = 2'd1,
        K_STORE = 2'd2
    } uop_kind_e;

    typedef struct packed {
        uop_kind_e           kind;
        logic                s0_en;
        logic [REG_W-1:0]    s0;
        logic                s1_en;
        logic [REG_W-1:0]    s1;
        logic                dst_en;
        logic [REG_W-1:0]    dst;
        logic [ADDR_W-1:0]   addr;
    } uop_t;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SCAN = 2'd1,
        ST_LOOP = 2'd2
    } scan_state_e;

    function automatic logic [NUM_REGS-1:0] reg_bit(input logic [REG_W-1:0] r);
        logic [NUM_REGS-1:0] v;
        v = '0;
        v[r] = 1'b1;
        return v;
    endfunction

endpackage

// File: rtl/lid_body_ram.sv
module lid_body_ram
    import lid_pkg::*;
#(
    parameter int N_ENT = 8,
    localparam int IDX_W = (N_ENT > 1) ? $clog2(N_ENT) : 1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  uop_t             wdata,
    output uop_t             body_o [N_ENT]
);

    uop_t slots_q [N_ENT];

    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_slot
            always_ff @(posedge clk) begin
                if (rst) begin
                    slots_q[g] <= '0;
                end else if (we && (int'(widx) == g)) begin
                    slots_q[g] <= wdata;
                end
            end
            assign body_o[g] = slots_q[g];
        end
    endgenerate

endmodule

// File: rtl/lid_scan.sv
module lid_scan
    import lid_pkg::*;
#(
    parameter int N_ENT     = 8,
    parameter int RLT_DEPTH = 2,
    localparam int LEN_W    = $clog2(N_ENT + 1),
    localparam int FILL_W   = $clog2(RLT_DEPTH + 1)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  uop_t                 body [N_ENT],
    input  logic [LEN_W-1:0]     len,
    input  logic                 start,
    input  logic                 leave,
    output logic                 idle_o,
    output logic                 loop_o,
    output logic                 clr_o,
    output logic [N_ENT-1:0]     red_o,
    output logic [RLT_DEPTH-1:0] alloc_we,
    output logic [ADDR_W-1:0]    alloc_addr [RLT_DEPTH]
);

    scan_state_e         state_q;
    logic [N_ENT-1:0]    red_q;
    logic [N_ENT-1:0]    gain;
    logic [N_ENT-1:0]    in_body;
    logic [NUM_REGS-1:0] stable;
    logic [FILL_W-1:0]   fill_q;
    logic [FILL_W-1:0]   fill_nx;
    logic [LEN_W-1:0]    pass_q;

    // Slots inside the body (R11)
    always_comb begin
        for (int i = 0; i < N_ENT; i++) begin
            in_body[i] = (i < int'(len));
        end
    end

    // A register is stable when every in-body writer is already marked
    always_comb begin
        stable = '1;
        for (int i = 0; i < N_ENT; i++) begin
            if (in_body[i] && body[i].dst_en && !red_q[i]) begin
                stable = stable & ~reg_bit(body[i].dst);
            end
        end
    end

    // New markings of this pass, loads limited by table room (R6)
    always_comb begin
        int fill_v;
        logic ok;
        gain     = '0;
        alloc_we = '0;
        for (int k = 0; k < RLT_DEPTH; k++) alloc_addr[k] = '0;
        fill_v   = int'(fill_q);
        for (int i = 0; i < N_ENT; i++) begin
            ok = in_body[i] && !red_q[i] && body[i].dst_en
                 && (body[i].kind != K_STORE)
                 && (!body[i].s0_en || stable[body[i].s0])
                 && (!body[i].s1_en || stable[body[i].s1]);
            if (ok && body[i].kind == K_LOAD) begin
                if (fill_v < RLT_DEPTH) begin
                    alloc_we[fill_v]   = (state_q == ST_SCAN);
                    alloc_addr[fill_v] = body[i].addr;
                    fill_v = fill_v + 1;
                end else begin
                    ok = 1'b0;
                end
            end
            gain[i] = ok;
        end
        fill_nx = FILL_W'(fill_v);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            red_q   <= '0;
            fill_q  <= '0;
            pass_q  <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        state_q <= ST_SCAN;
                        red_q   <= '0;
                        fill_q  <= '0;
                        pass_q  <= '0;
                    end
                end
                ST_SCAN: begin
                    red_q  <= red_q | gain;
                    fill_q <= fill_nx;
                    pass_q <= pass_q + 1'b1;
                    if ((gain == '0) || (int'(pass_q) + 1 >= int'(len))) begin
                        state_q <= ST_LOOP;
                    end
                end
                ST_LOOP: begin
                    if (leave) begin
                        state_q <= ST_IDLE;
                        red_q   <= '0;
                        fill_q  <= '0;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign idle_o = (state_q == ST_IDLE);
    assign loop_o = (state_q == ST_LOOP);
    assign clr_o  = ((state_q == ST_IDLE) && start) || ((state_q == ST_LOOP) && leave);
    assign red_o  = red_q;

    // R2: markings only grow while the analysis runs
    p_marks_grow_r2: assert property (@(posedge clk) disable iff (rst)
        (state_q == ST_SCAN) |=> ((red_q & $past(red_q)) == $past(red_q)));

    // R4: a stored STORE slot never carries a marking
    generate
        for (genvar g = 0; g < N_ENT; g++) begin : g_chk
            p_store_unmarked_r4: assert property (@(posedge clk) disable iff (rst)
                red_q[g] |-> (body[g].kind != K_STORE));
        end
    endgenerate

endmodule

// File: rtl/lid_rlt.sv
module lid_rlt
    import lid_pkg::*;
#(
    parameter int RLT_DEPTH = 2
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clr,
    input  logic [RLT_DEPTH-1:0] alloc_we,
    input  logic [ADDR_W-1:0]    alloc_addr [RLT_DEPTH],
    input  logic                 chk_en,
    input  logic                 st_valid,
    input  logic [ADDR_W-1:0]    st_addr,
    output logic                 hit_o,
    output logic [RLT_DEPTH-1:0] occ_o
);

    logic [RLT_DEPTH-1:0] vld_q;
    logic [ADDR_W-1:0]    addr_q [RLT_DEPTH];
    logic [RLT_DEPTH-1:0] match;

    generate
        for (genvar k = 0; k < RLT_DEPTH; k++) begin : g_way
            always_ff @(posedge clk) begin
                if (rst || clr) begin
                    vld_q[k]  <= 1'b0;
                    addr_q[k] <= '0;
                end else if (alloc_we[k]) begin
                    vld_q[k]  <= 1'b1;
                    addr_q[k] <= alloc_addr[k];
                end
            end
            assign match[k] = vld_q[k] && (addr_q[k] == st_addr);
        end
    endgenerate

    assign hit_o = chk_en && st_valid && (match != '0);
    assign occ_o = vld_q;

    // R6: slots fill from the bottom without holes
    p_fill_ordered_r6: assert property (@(posedge clk) disable iff (rst)
        ((vld_q & (vld_q + 1'b1)) == '0));

endmodule

// File: rtl/loop_invariant_detector.sv
module loop_invariant_detector
    import lid_pkg::*;
#(
    parameter int N_ENT     = 8,
    parameter int RLT_DEPTH = 2,
    localparam int IDX_W    = (N_ENT > 1) ? $clog2(N_ENT) : 1,
    localparam int LEN_W    = $clog2(N_ENT + 1)
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                wr_en,
    input  logic [IDX_W-1:0]    wr_idx,
    input  logic [1:0]          wr_kind,
    input  logic                wr_src0_en,
    input  logic [REG_W-1:0]    wr_src0,
    input  logic                wr_src1_en,
    input  logic [REG_W-1:0]    wr_src1,
    input  logic                wr_dst_en,
    input  logic [REG_W-1:0]    wr_dst,
    input  logic [ADDR_W-1:0]   wr_addr,
    input  logic [LEN_W-1:0]    body_len,
    input  logic                start,
    input  logic                loop_end,
    input  logic                st_valid,
    input  logic [ADDR_W-1:0]   st_addr,
    output logic                loop_mode,
    output logic [N_ENT-1:0]    red_mask,
    output logic [NUM_REGS-1:0] pin_mask,
    output logic                flush_req,
    output logic                restore_req
);

    uop_t                 wdata;
    uop_t                 body [N_ENT];
    logic                 idle;
    logic                 in_loop;
    logic                 clr;
    logic                 hit;
    logic                 leave;
    logic [N_ENT-1:0]     red;
    logic [N_ENT-1:0]     red_loads;
    logic [RLT_DEPTH-1:0] alloc_we;
    logic [ADDR_W-1:0]    alloc_addr [RLT_DEPTH];
    logic [RLT_DEPTH-1:0] occ;

    always_comb begin
        wdata.kind   = uop_kind_e'(wr_kind);
        wdata.s0_en  = wr_src0_en;
        wdata.s0     = wr_src0;
        wdata.s1_en  = wr_src1_en;
        wdata.s1     = wr_src1;
        wdata.dst_en = wr_dst_en;
        wdata.dst    = wr_dst;
        wdata.addr   = wr_addr;
    end

    lid_body_ram #(.N_ENT(N_ENT)) u_body (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_en && idle),
        .widx   (wr_idx),
        .wdata  (wdata),
        .body_o (body)
    );

    lid_scan #(.N_ENT(N_ENT), .RLT_DEPTH(RLT_DEPTH)) u_scan (
        .clk        (clk),
        .rst        (rst),
        .body       (body),
        .len        (body_len),
        .start      (start),
        .leave      (leave),
        .idle_o     (idle),
        .loop_o     (in_loop),
        .clr_o      (clr),
        .red_o      (red),
        .alloc_we   (alloc_we),
        .alloc_addr (alloc_addr)
    );

    lid_rlt #(.RLT_DEPTH(RLT_DEPTH)) u_rlt (
        .clk        (clk),
        .rst        (rst),
        .clr        (clr),
        .alloc_we   (alloc_we),
        .alloc_addr (alloc_addr),
        .chk_en     (in_loop),
        .st_valid   (st_valid),
        .st_addr    (st_addr),
        .hit_o      (hit),
        .occ_o      (occ)
    );

    assign leave = in_loop && (hit || loop_end);

    always_ff @(posedge clk) begin
        if (rst) begin
            flush_req   <= 1'b0;
            restore_req <= 1'b0;
        end else begin
            flush_req   <= hit;
            restore_req <= leave;
        end
    end

    always_comb begin
        pin_mask  = '0;
        red_loads = '0;
        for (int i = 0; i < N_ENT; i++) begin
            if (in_loop && red[i] && body[i].dst_en) begin
                pin_mask = pin_mask | reg_bit(body[i].dst);
            end
            red_loads[i] = red[i] && (body[i].kind == K_LOAD);
        end
    end

    assign loop_mode = in_loop;
    assign red_mask  = in_loop ? red : '0;

    // R6: every marked load holds exactly one table slot
    p_table_matches_loads_r6: assert property (@(posedge clk) disable iff (rst)
        in_loop |-> ($countones(red_loads) == $countones(occ)));

    // R7: a conflict flush is a single cycle and loop mode is already over
    p_flush_single_r7: assert property (@(posedge clk) disable iff (rst)
        flush_req |=> !flush_req);
    p_flush_outside_loop_r7: assert property (@(posedge clk) disable iff (rst)
        flush_req |-> (!loop_mode && restore_req));

    // R9: leaving loop mode always comes with a restore request
    p_restore_on_exit_r9: assert property (@(posedge clk) disable iff (rst)
        $fell(in_loop) |-> restore_req);

endmodule

// File: tb/sim_loop_invariant_detector.sv
module sim_loop_invariant_detector;
    import lid_pkg::*;

    localparam int N_ENT = 8;
    localparam int DEPTH = 2;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic [2:0]  wr_idx = '0;
    logic [1:0]  wr_kind = '0;
    logic        wr_src0_en = 1'b0;
    logic [3:0]  wr_src0 = '0;
    logic        wr_src1_en = 1'b0;
    logic [3:0]  wr_src1 = '0;
    logic        wr_dst_en = 1'b0;
    logic [3:0]  wr_dst = '0;
    logic [15:0] wr_addr = '0;
    logic [3:0]  body_len = '0;
    logic        start = 1'b0;
    logic        loop_end = 1'b0;
    logic        st_valid = 1'b0;
    logic [15:0] st_addr = '0;
    logic        loop_mode;
    logic [7:0]  red_mask;
    logic [15:0] pin_mask;
    logic        flush_req;
    logic        restore_req;

    int errors = 0;
    int checks = 0;

    always #2.5 clk = ~clk;

    loop_invariant_detector #(.N_ENT(N_ENT), .RLT_DEPTH(DEPTH)) u0 (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_idx(wr_idx), .wr_kind(wr_kind),
        .wr_src0_en(wr_src0_en), .wr_src0(wr_src0), .wr_src1_en(wr_src1_en),
        .wr_src1(wr_src1), .wr_dst_en(wr_dst_en), .wr_dst(wr_dst), .wr_addr(wr_addr),
        .body_len(body_len), .start(start), .loop_end(loop_end), .st_valid(st_valid),
        .st_addr(st_addr), .loop_mode(loop_mode), .red_mask(red_mask),
        .pin_mask(pin_mask), .flush_req(flush_req), .restore_req(restore_req)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic put(input int idx, input int kind, input bit e0, input int s0,
                       input bit e1, input int s1, input bit ed, input int d, input int a);
        @(negedge clk);
        wr_en = 1'b1; wr_idx = 3'(idx); wr_kind = 2'(kind);
        wr_src0_en = e0; wr_src0 = 4'(s0); wr_src1_en = e1; wr_src1 = 4'(s1);
        wr_dst_en = ed; wr_dst = 4'(d); wr_addr = 16'(a);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    // Start an analysis and wait at a negedge until loop mode is reached
    task automatic run(input int len);
        @(negedge clk);
        body_len = 4'(len);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check("R10 no loop mode while analysing", {31'd0, loop_mode}, 32'd0);
        check("R10 mask zero while analysing", {24'd0, red_mask}, 32'd0);
        for (int w = 0; w < 40 && !loop_mode; w++) @(negedge clk);
        check("loop mode reached", {31'd0, loop_mode}, 32'd1);
    endtask

    task automatic store(input int a);
        st_valid = 1'b1; st_addr = 16'(a);
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    task automatic t_reset;
        check("R10 reset loop_mode", {31'd0, loop_mode}, 32'd0);
        check("R10 reset red_mask", {24'd0, red_mask}, 32'd0);
        check("R5 reset pin_mask", {16'd0, pin_mask}, 32'd0);
        check("R7 reset flush_req", {31'd0, flush_req}, 32'd0);
    endtask

    // ALU body: chain, self-increment, store, slot past the body end
    task automatic t_chain;
        put(0, 0, 1, 9, 1, 10, 1, 2, 0);   // r2 = f(r9,r10)     invariant
        put(1, 0, 1, 2, 1, 9, 1, 3, 0);    // r3 = f(r2,r9)      via chain
        put(2, 0, 1, 4, 1, 3, 1, 4, 0);    // r4 = f(r4,r3)      self reader
        put(3, 0, 1, 4, 0, 0, 1, 5, 0);    // r5 = f(r4)         depends on e2
        put(4, 2, 1, 2, 0, 0, 0, 0, 0);    // store from r2
        put(5, 0, 1, 9, 0, 0, 1, 9, 0);    // outside body: writes r9
        put(6, 0, 1, 11, 0, 0, 1, 7, 0);   // outside body: invariant form
        run(5);
        check("R1 R2 chain marked, R3 R4 R11 others clear", {24'd0, red_mask}, 32'h03);
        check("R5 pin regs r2 r3", {16'd0, pin_mask}, 32'h000C);
        @(negedge clk);
        loop_end = 1'b1;
        @(negedge clk);
        loop_end = 1'b0;
        check("R9 restore on loop_end", {31'd0, restore_req}, 32'd1);
        check("R9 no flush on loop_end", {31'd0, flush_req}, 32'd0);
        check("R9 loop mode ends", {31'd0, loop_mode}, 32'd0);
        check("R5 pin cleared after exit", {16'd0, pin_mask}, 32'd0);
    endtask

    // Register with one marked and one unmarked writer
    task automatic t_mixed;
        put(0, 0, 1, 12, 0, 0, 1, 6, 0);   // r6 = f(r12)       invariant
        put(1, 0, 1, 6, 0, 0, 1, 6, 0);    // r6 = f(r6)        self reader
        put(2, 0, 1, 6, 0, 0, 1, 8, 0);    // r8 = f(r6)        mixed writers
        run(3);
        check("R3 mixed writers block marking", {24'd0, red_mask}, 32'h01);
        check("R5 pin r6 only", {16'd0, pin_mask}, 32'h0040);
        @(negedge clk);
        loop_end = 1'b1;
        @(negedge clk);
        loop_end = 1'b0;
    endtask

    // Loads with a table of two slots, then stores
    task automatic t_loads;
        put(0, 1, 1, 9, 0, 0, 1, 2, 'h100);
        put(1, 1, 1, 9, 0, 0, 1, 3, 'h200);
        put(2, 1, 1, 9, 0, 0, 1, 4, 'h300);
        put(3, 0, 1, 2, 1, 3, 1, 5, 0);
        run(4);
        check("R6 third load left unmarked", {24'd0, red_mask}, 32'h0B);
        check("R5 pins r2 r3 r5", {16'd0, pin_mask}, 32'h002C);
        store('h300);
        check("R8 untracked store no flush", {31'd0, flush_req}, 32'd0);
        check("R8 loop mode kept", {31'd0, loop_mode}, 32'd1);
        check("R8 mask kept", {24'd0, red_mask}, 32'h0B);
        store('h200);
        check("R7 flush on conflict", {31'd0, flush_req}, 32'd1);
        check("R7 restore on conflict", {31'd0, restore_req}, 32'd1);
        check("R7 loop mode off", {31'd0, loop_mode}, 32'd0);
        check("R7 mask cleared", {24'd0, red_mask}, 32'd0);
        check("R7 pin cleared", {16'd0, pin_mask}, 32'd0);
        @(negedge clk);
        check("R7 flush is one cycle", {31'd0, flush_req}, 32'd0);
        run(4);
        check("R7 table emptied, same marks again", {24'd0, red_mask}, 32'h0B);
        store('h100);
        check("R7 first slot still tracked", {31'd0, flush_req}, 32'd1);
    endtask

    initial begin : watchdog
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Result: errors=%0d of %0d checks", errors, checks + 1);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        t_reset();
        t_chain();
        t_mixed();
        t_loads();
        repeat (2) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule